// File: doc/BRIEF.md
# Multi-channel double-buffered PWM generator

The block produces several independent pulse-width modulated outputs from one clock. Each channel owns a small register bank holding a duty count and a period word. The period word carries the period length, a prescaler select and two 2-bit output states: one for the active part of each period and one for the rest. Software programs a channel through a plain single-cycle write port. It writes the duty register and then the period word. The pair is kept in a staging copy and moves into the running counter only when the current period runs out, so a reprogrammed channel never shows a truncated or stretched pulse.

A shared enable register turns channels on and off. It is reached through two write addresses. One sets every channel whose data bit is one. The other clears every channel whose data bit is one. Channels whose bits are zero keep their state, so two agents can drive different channels without a read-modify-write. A stopped channel rests at its idle level. Starting a channel loads its staged values at once, without waiting for a period boundary.

Top module: `pwmBank`

## Requirements
- R1: While reset is asserted and after its release, every enable bit is clear, all staged and running settings are zero and every output is low.
- R2: Address decoding uses byte addresses. The enable set address is 0x04 and the enable clear address is 0x08. Channel n has its bank at 0x20 + 0x20*n, with the duty register at bank offset 0x00 and the period word at bank offset 0x10. Writes to any other address have no effect, and a write to one channel's bank leaves every other channel unchanged.
- R3: The duty count is taken from bits [31:16] of the duty register. The period word holds the period field in bits [15:0]. A period lasts field+1 counter steps. The output is in its active state while the counter is below the duty count and in its idle state for the rest of the period. A duty count of zero keeps the output idle for the whole period, and a duty count above the field keeps it active for the whole period.
- R4: Bits [17:16] of the period word give the active state and bits [19:18] give the idle state. State 3 drives the pin high. States 0, 1 and 2 drive it low.
- R5: Bits [22:20] of the period word select the prescaler. Values 0 to 7 step the counter once every 1, 2, 4, 8, 16, 64, 256 and 1024 clocks respectively.
- R6: A duty register write that is not followed by a period word write never reaches the running channel.
- R7: A period word write arms a commit. Both staged values are applied together at the clock edge on which the running period ends, and the new period starts from count zero. A period word written in the very cycle the running period ends is applied at that same edge.
- R8: A write to the set address turns on the channels whose data bits [NUM_CH-1:0] are one, and a write to the clear address turns them off. Channels whose bits are zero keep their state. Setting a channel that is already running does not restart it.
- R9: A stopped channel holds its counter at zero and drives the idle state of its last applied settings. Turning a channel on applies its staged values at that edge, and counting starts from zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per high cycle |
| wrAddr | input | ADDR_W (8) | Byte address of the write |
| wrData | input | DATA_W (32) | Write data |
| pwmOut | output | NUM_CH (4) | One modulated output per channel |

## Verification
Two events can land on the same clock edge: a period word write and the natural end of the running period. That edge decides whether the write is applied at once or a whole period later. The bench tracks each channel's phase from the edge that turned it on, waits until the next edge is a boundary, and issues the write on exactly that cycle. It then expects the new shape to start at count zero from the following cycle. A second collision comes from a set-address write hitting a channel that is already running. The bench judges it by checking that the channel's waveform continues in phase without a restart.

// File: rtl/pwmBankPkg.sv
package pwmBankPkg;
  localparam int CNT_W    = 16;
  localparam int LVL_W    = 2;
  localparam int SEL_W    = 3;
  localparam int PRE_W    = 10;
  localparam int DUTY_LSB = 16;
  localparam int CFG_W    = CNT_W + 2 * LVL_W + SEL_W;
  localparam logic [LVL_W-1:0] LVL_HIGH = 2'd3;

  // layout matches the period word: [22:20] sel, [19:18] idle, [17:16] active, [15:0] period
  typedef struct packed {
    logic [SEL_W-1:0] divSel;
    logic [LVL_W-1:0] idleLvl;
    logic [LVL_W-1:0] actLvl;
    logic [CNT_W-1:0] perCnt;
  } perCfg_t;

  typedef struct packed {
    logic dutyWr;
    logic perWr;
    logic enLoad;
    logic chEn;
  } chStrobe_t;

  // prescaler terminal count (ratio minus one) for a select value
  function automatic logic [PRE_W-1:0] divLimit(input logic [SEL_W-1:0] sel);
    int sh;
    sh = (sel < 3'd5) ? int'(sel) : 2 * int'(sel) - 4;
    return PRE_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/pwmBankCtrl.sv
module pwmBankCtrl
  import pwmBankPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 8,
  parameter int SET_ADDR    = 'h04,
  parameter int CLR_ADDR    = 'h08,
  parameter int BANK_BASE   = 'h20,
  parameter int BANK_STRIDE = 'h20,
  parameter int PER_OFS     = 'h10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [NUM_CH-1:0]        reqBits,
  output chStrobe_t [NUM_CH-1:0]   strb,
  output logic [NUM_CH-1:0]        enVec
);
  logic setHit;
  logic clrHit;
  logic [NUM_CH-1:0] enReg;

  assign setHit = wrEn && (wrAddr == ADDR_W'(SET_ADDR));
  assign clrHit = wrEn && (wrAddr == ADDR_W'(CLR_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
    end else if (setHit) begin
      enReg <= enReg | reqBits;
    end else if (clrHit) begin
      enReg <= enReg & ~reqBits;
    end
  end

  assign enVec = enReg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    localparam int DUTY_ADDR = BANK_BASE + ch * BANK_STRIDE;
    localparam int PER_ADDR  = DUTY_ADDR + PER_OFS;
    assign strb[ch].dutyWr = wrEn && (wrAddr == ADDR_W'(DUTY_ADDR));
    assign strb[ch].perWr  = wrEn && (wrAddr == ADDR_W'(PER_ADDR));
    assign strb[ch].enLoad = setHit && reqBits[ch] && !enReg[ch];
    assign strb[ch].chEn   = enReg[ch];
  end
endmodule

// File: rtl/pwmChannel.sv
module pwmChannel
  import pwmBankPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmOut,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  livePer
);
  logic [CNT_W-1:0] dutyStage, dutyStageNx, dutyLive;
  perCfg_t          perStage, perStageNx, liveCfg;
  logic             pend, pendNx;
  logic [PRE_W-1:0] pre;
  logic             tick, wrapNow, commit;
  logic [LVL_W-1:0] lvl;

  // a write landing in the boundary cycle is seen by the commit
  assign dutyStageNx = strb.dutyWr ? wrData[DUTY_LSB +: CNT_W] : dutyStage;
  assign perStageNx  = strb.perWr ? perCfg_t'(wrData[CFG_W-1:0]) : perStage;
  assign pendNx      = pend | strb.perWr;

  assign tick    = (pre == divLimit(liveCfg.divSel));
  assign wrapNow = strb.chEn && tick && (cnt == liveCfg.perCnt);
  assign commit  = strb.enLoad || (wrapNow && pendNx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyStage <= '0;
      perStage  <= '0;
      dutyLive  <= '0;
      liveCfg   <= '0;
      pend      <= 1'b0;
      pre       <= '0;
      cnt       <= '0;
    end else begin
      dutyStage <= dutyStageNx;
      perStage  <= perStageNx;
      pend      <= commit ? 1'b0 : pendNx;
      if (commit) begin
        dutyLive <= dutyStageNx;
        liveCfg  <= perStageNx;
      end
      if (strb.enLoad || !strb.chEn) begin
        pre <= '0;
        cnt <= '0;
      end else if (tick) begin
        pre <= '0;
        cnt <= (cnt == liveCfg.perCnt) ? '0 : cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_comb begin
    if (!strb.chEn)           lvl = liveCfg.idleLvl;
    else if (cnt < dutyLive)  lvl = liveCfg.actLvl;
    else                      lvl = liveCfg.idleLvl;
  end

  assign pwmOut  = (lvl == LVL_HIGH);
  assign livePer = liveCfg.perCnt;
endmodule

// File: rtl/pwmBankPath.sv
module pwmBankPath
  import pwmBankPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  chStrobe_t [NUM_CH-1:0]    strb,
  input  logic [DATA_W-1:0]         wrData,
  output logic [NUM_CH-1:0]         pwmOut,
  output logic [NUM_CH*CNT_W-1:0]   cntFlat,
  output logic [NUM_CH*CNT_W-1:0]   perFlat
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwmChannel #(.DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb[ch]),
      .wrData  (wrData),
      .pwmOut  (pwmOut[ch]),
      .cnt     (cntFlat[ch*CNT_W +: CNT_W]),
      .livePer (perFlat[ch*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/pwmBank.sv
module pwmBank
  import pwmBankPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SET_ADDR    = 'h04,
  parameter int CLR_ADDR    = 'h08,
  parameter int BANK_BASE   = 'h20,
  parameter int BANK_STRIDE = 'h20,
  parameter int PER_OFS     = 'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [NUM_CH-1:0] pwmOut
);
  chStrobe_t [NUM_CH-1:0]  strb;
  logic [NUM_CH-1:0]       enVec;
  logic [NUM_CH*CNT_W-1:0] cntFlat;
  logic [NUM_CH*CNT_W-1:0] perFlat;

  pwmBankCtrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR),
    .BANK_BASE(BANK_BASE), .BANK_STRIDE(BANK_STRIDE), .PER_OFS(PER_OFS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .reqBits (wrData[NUM_CH-1:0]),
    .strb    (strb),
    .enVec   (enVec)
  );

  pwmBankPath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .pwmOut  (pwmOut),
    .cntFlat (cntFlat),
    .perFlat (perFlat)
  );
endmodule

// File: rtl/pwmBankChk.sv
module pwmBankChk
  import pwmBankPkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int SET_ADDR = 'h04,
  parameter int CLR_ADDR = 'h08
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic [ADDR_W-1:0]       wrAddr,
  input logic [NUM_CH-1:0]       reqBits,
  input logic [NUM_CH-1:0]       enVec,
  input logic [NUM_CH*CNT_W-1:0] cntFlat,
  input logic [NUM_CH*CNT_W-1:0] perFlat
);
  logic ctrlHit;
  assign ctrlHit = wrEn && ((wrAddr == ADDR_W'(SET_ADDR)) || (wrAddr == ADDR_W'(CLR_ADDR)));

  p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlHit |=> $stable(enVec));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_set_alias_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(SET_ADDR) && reqBits[i]) |=> enVec[i]);

    p_clear_alias_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == ADDR_W'(CLR_ADDR) && reqBits[i]) |=> !enVec[i]);

    p_idle_cnt_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
      !enVec[i] |=> (cntFlat[i*CNT_W +: CNT_W] == '0));

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
      cntFlat[i*CNT_W +: CNT_W] <= perFlat[i*CNT_W +: CNT_W]);

    p_commit_at_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(perFlat[i*CNT_W +: CNT_W]) |-> (cntFlat[i*CNT_W +: CNT_W] == '0));
  end
endmodule

bind pwmBank pwmBankChk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .reqBits (wrData[NUM_CH-1:0]),
  .enVec   (enVec),
  .cntFlat (cntFlat),
  .perFlat (perFlat)
);

// File: tb/sim_pwmBank.sv
`timescale 1ns/1ps
module sim_pwmBank;
  localparam int NCH = 4;
  localparam int SETA = 'h04, CLRA = 'h08;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [NCH-1:0] pwmOut;

  pwmBank u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  int segStart[NCH], segP[NCH], segD[NCH], segAct[NCH], segIdle[NCH], segDiv[NCH];
  bit segOn[NCH];
  int stP[NCH], stD[NCH], stAct[NCH], stIdle[NCH], stSel[NCH];

  function automatic int divOf(int sel);
    return (sel < 5) ? (1 << sel) : (1 << (2 * sel - 4));
  endfunction

  function automatic bit expOut(int ch);
    int k, c;
    if (!segOn[ch]) return segIdle[ch] == 3;
    k = cyc - segStart[ch];
    c = (k / segDiv[ch]) % (segP[ch] + 1);
    return (c < segD[ch]) ? (segAct[ch] == 3) : (segIdle[ch] == 3);
  endfunction

  task automatic check(input bit got, input bit want, input string tag, input int ch);
    nChecks++;
    if (got !== want) begin
      nFails++;
      $display("FAIL %s ch%0d cyc %0d: got %0b expected %0b", tag, ch, cyc, got, want);
    end
  endtask

  task automatic observe(input int ch, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pwmOut[ch], expOut(ch), tag, ch);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    wrAddr = 8'(addr);
    wrData = data;
    wrEn = 1'b1;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic wrDuty(input int ch, input int d);
    wr('h20 + 'h20 * ch, 32'(d) << 16);
    stD[ch] = d;
  endtask

  task automatic wrPer(input int ch, input int p, input int act, input int idle, input int sel);
    wr('h30 + 'h20 * ch, (32'(sel) << 20) | (32'(idle) << 18) | (32'(act) << 16) | 32'(p));
    stP[ch] = p; stAct[ch] = act; stIdle[ch] = idle; stSel[ch] = sel;
  endtask

  task automatic commitModel(input int ch);
    segP[ch] = stP[ch]; segD[ch] = stD[ch]; segAct[ch] = stAct[ch];
    segIdle[ch] = stIdle[ch]; segDiv[ch] = divOf(stSel[ch]);
  endtask

  task automatic chOn(input int mask);
    wr(SETA, 32'(mask));
    for (int ch = 0; ch < NCH; ch++)
      if (mask[ch] && !segOn[ch]) begin
        commitModel(ch);
        segStart[ch] = cyc;
        segOn[ch] = 1'b1;
      end
  endtask

  task automatic chOff(input int mask);
    wr(CLRA, 32'(mask));
    for (int ch = 0; ch < NCH; ch++) if (mask[ch]) segOn[ch] = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int lvA[4], lvI[4];
    int w, c;
    lvA = '{3, 2, 3, 1};
    lvI = '{2, 3, 0, 3};
    for (int ch = 0; ch < NCH; ch++) begin
      segOn[ch] = 0; segIdle[ch] = 0; segStart[ch] = 0; segP[ch] = 0; segD[ch] = 0;
      segAct[ch] = 0; segDiv[ch] = 1;
      stP[ch] = 0; stD[ch] = 0; stAct[ch] = 0; stIdle[ch] = 0; stSel[ch] = 0;
    end

    // R1: outputs low in reset and just after
    repeat (4) @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) check(pwmOut[ch], 1'b0, "R1 in reset", ch);
    rstN = 1'b1;
    for (int ch = 0; ch < NCH; ch++) observe(ch, 2, "R1 after reset");

    // R3 R4 R9: sweep period, duty and level pairs on channel 0
    for (int lv = 0; lv < 4; lv++)
      for (int p = 0; p < 4; p++)
        for (int d = 0; d <= p + 2; d++) begin
          wrDuty(0, d);
          wrPer(0, p, lvA[lv], lvI[lv], 0);
          chOn(1);
          observe(0, 2 * (p + 1) + 1, "R3 R4 waveform");
          chOff(1);
          observe(0, 2, "R9 stopped idle level");
        end

    // R5: every prescaler select
    for (int sel = 0; sel < 8; sel++) begin
      wrDuty(1, 1);
      wrPer(1, 1, 3, 2, sel);
      chOn(2);
      observe(1, 4 * divOf(sel) + 2, "R5 prescaler");
      chOff(2);
    end

    // R2 R9: bank isolation, stray addresses, stopped channel ignores staged levels
    wrDuty(2, 2);
    wrPer(2, 4, 3, 2, 0);
    chOn(4);
    observe(2, 6, "R2 base run");
    wrDuty(3, 5);
    wrPer(3, 6, 2, 3, 1);
    observe(3, 3, "R9 stopped ch uses applied idle");
    wr('h0C, 32'hFFFF_FFFF);
    wr('h00, 32'hFFFF_FFFF);
    wr('h34, 32'h0000_0001);
    observe(2, 8, "R2 other writes ignored");
    chOn(8);
    observe(3, 20, "R9 enable loads staged");

    // R8: redundant set, selective clear
    wr(SETA, 32'h4);
    observe(2, 12, "R8 set on running ch no restart");
    chOff(8);
    observe(2, 10, "R8 clear leaves other bits");
    observe(3, 4, "R8 cleared ch idle");

    // R6 R7: duty-only write stays pending, period write commits at boundary
    wrDuty(0, 2);
    wrPer(0, 7, 3, 2, 0);
    chOn(1);
    observe(0, 5, "R6 base");
    wrDuty(0, 3);
    observe(0, 20, "R6 duty alone pending");
    wrPer(0, 3, 3, 2, 0);
    w = cyc - segStart[0];
    c = ((w + 7) / 8) * 8;
    observe(0, c - w, "R7 old shape until boundary");
    commitModel(0);
    segStart[0] = segStart[0] + c;
    observe(0, 16, "R7 new shape after boundary");

    // R7: period write landing on the boundary cycle
    while (((cyc + 1 - segStart[0]) % 4) != 0) @(negedge clk);
    wrPer(0, 5, 2, 3, 0);
    commitModel(0);
    segStart[0] = cyc;
    observe(0, 18, "R7 write in boundary cycle");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule